// File: doc/BRIEF.md
# Multiplexed-Bus Address Latch and Decoder

This block sits between a processor whose address and data share one bus and the external devices behind it. While the address-latch-enable strobe is high, the block captures the shared bus into an address register. Once the strobe drops, it holds that address for the rest of the cycle. The block then maps the held 16-bit address onto three active-low chip selects: one for a RAM, one for a ROM, and one for a write-only output port.

The memory map is fixed and uses overlapping priority. RAM owns the top 8 KB. The output port owns a 512-byte window just below the RAM, and every address inside that window reaches the same port. The port select also needs a clean write: the write strobe low and the read strobe high. ROM is the default device. It is suppressed for any address in the RAM window or the port window, whatever the strobes are doing, so a read inside the port window selects no device at all.

All state is clocked. Reset is synchronous and active high. The address register loads on every clock edge at which the enable strobe is sampled high. The selects are registered one edge later, from the held address and the strobes sampled at that edge.

Top module: `mux_bus_addr_decoder`

## Requirements
- R1: While `rst` is high, `addr_o` reads 0 and all three selects (`ram_sel_n_o`, `rom_sel_n_o`, `port_sel_n_o`) read 1 (inactive).
- R2: At any clock edge where `ale_i` is sampled high, `addr_o` takes the value of `ad_i`, and it is visible after that edge.
- R3: At any clock edge where `ale_i` is sampled low, `addr_o` keeps its value whatever `ad_i` does.
- R4: After each edge, `ram_sel_n_o` is 0 exactly when bits [15:13] of the held address seen at that edge are all 1 (0xE000–0xFFFF). The read and write strobes do not affect it.
- R5: After each edge, `port_sel_n_o` is 0 when all three of these hold at that edge: bits [15:9] of the held address equal 7'b1101111 (0xDE00–0xDFFF), `wr_n_i` is 0, and `rd_n_i` is 1. Address bits [8:0] have no effect.
- R6: `port_sel_n_o` stays 1 when the strobes at the preceding edge show a read (`rd_n_i`=0, `wr_n_i`=1), an idle bus (both 1) or a clash (both 0), even inside the port window.
- R7: After each edge, `rom_sel_n_o` is 0 exactly when the held address is in 0x0000–0xDDFF, for any strobe combination. This means it is 1 for every access in 0xDE00–0xFFFF, reads included.
- R8: At most one of the three selects is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 16 | Shared address/data bus |
| ale_i | input | 1 | Address-latch enable; high during the address phase |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_o | output | 16 | Held address |
| ram_sel_n_o | output | 1 | RAM select, active low |
| rom_sel_n_o | output | 1 | ROM select, active low |
| port_sel_n_o | output | 1 | Output-port select, active low |

## Verification
The hardest case to reach is a map edge combined with a specific strobe pairing. Examples are a read or a strobe clash inside the 512-byte port window, where no device may be selected, and the addresses on either side of 0xDE00 and 0xE000. The bench holds the enable strobe high and streams one new address per clock, which keeps the register pipeline full. It checks each select one edge after the address enters. It walks the whole 64 KB space with a clean write, and it walks the upper region one address at a time (with a coarse stride below it) for the read, idle and clash pairings. A separate scenario drops the enable strobe and then drives unrelated values onto the bus to show that the held address and the select derived from it do not move.

// File: rtl/adl_pkg.sv
package adl_pkg;

  localparam int ADDR_W = 16;

  // Internal select vector, active high; the top inverts it at the pins.
  typedef struct packed {
    logic ram;
    logic port;
    logic rom;
  } sel_t;

  typedef enum logic [1:0] {
    STB_IDLE  = 2'd0,
    STB_READ  = 2'd1,
    STB_WRITE = 2'd2,
    STB_CLASH = 2'd3
  } strobe_e;

  function automatic strobe_e classify_strobes(input logic rd_n, input logic wr_n);
    strobe_e s;
    case ({rd_n, wr_n})
      2'b11:   s = STB_IDLE;
      2'b01:   s = STB_READ;
      2'b10:   s = STB_WRITE;
      default: s = STB_CLASH;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/adl_capture.sv
module adl_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ale_i,
  input  logic [W-1:0] ad_i,
  output logic [W-1:0] addr_o
);

  logic [W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (ale_i) begin
      addr_q <= ad_i;
    end
  end

  assign addr_o = addr_q;

  // R2
  ale_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ale_i |=> (addr_q == $past(ad_i)));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ale_i |=> $stable(addr_q));

endmodule

// File: rtl/adl_window_match.sv
module adl_window_match #(
  parameter int           W     = 16,
  parameter logic [W-1:0] MASK  = '1,
  parameter logic [W-1:0] MATCH = '0
) (
  input  logic [W-1:0] addr_i,
  output logic         hit_o
);

  // Bits outside MASK are don't-care, so the window aliases across them.
  localparam logic [W-1:0] MATCH_M = MATCH & MASK;

  assign hit_o = ((addr_i & MASK) == MATCH_M);

endmodule

// File: rtl/adl_select_arbiter.sv
module adl_select_arbiter
  import adl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ram_hit_i,
  input  logic port_hit_i,
  input  logic rd_n_i,
  input  logic wr_n_i,
  output sel_t sel_o
);

  strobe_e stb;
  sel_t    sel_d;
  sel_t    sel_q;

  assign stb = classify_strobes(rd_n_i, wr_n_i);

  // Priority: RAM window, then port window, then ROM as default.
  always_comb begin
    sel_d      = '0;
    sel_d.ram  = ram_hit_i;
    sel_d.port = !ram_hit_i && port_hit_i && (stb == STB_WRITE);
    sel_d.rom  = !ram_hit_i && !port_hit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

  // R8
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));

  // R6
  port_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    sel_q.port |-> ($past(!wr_n_i) && $past(rd_n_i)));

  // R7
  rom_excl_chk: assert property (@(posedge clk) disable iff (rst)
    sel_q.rom |-> ($past(!ram_hit_i) && $past(!port_hit_i)));

  // R4
  ram_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ram_hit_i)) |-> sel_q.ram);

endmodule

// File: rtl/mux_bus_addr_decoder.sv
module mux_bus_addr_decoder
  import adl_pkg::*;
#(
  parameter int           W          = ADDR_W,
  parameter logic [W-1:0] RAM_MASK   = 16'hE000,
  parameter logic [W-1:0] RAM_MATCH  = 16'hE000,
  parameter logic [W-1:0] PORT_MASK  = 16'hFE00,
  parameter logic [W-1:0] PORT_MATCH = 16'hDE00
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ad_i,
  input  logic         ale_i,
  input  logic         rd_n_i,
  input  logic         wr_n_i,
  output logic [W-1:0] addr_o,
  output logic         ram_sel_n_o,
  output logic         rom_sel_n_o,
  output logic         port_sel_n_o
);

  logic [W-1:0] addr_held;
  logic         ram_hit;
  logic         port_hit;
  sel_t         sel;

  adl_capture #(.W(W)) capture_i (
    .clk    (clk),
    .rst    (rst),
    .ale_i  (ale_i),
    .ad_i   (ad_i),
    .addr_o (addr_held)
  );

  adl_window_match #(.W(W), .MASK(RAM_MASK), .MATCH(RAM_MATCH)) ram_win_i (
    .addr_i (addr_held),
    .hit_o  (ram_hit)
  );

  adl_window_match #(.W(W), .MASK(PORT_MASK), .MATCH(PORT_MATCH)) port_win_i (
    .addr_i (addr_held),
    .hit_o  (port_hit)
  );

  adl_select_arbiter arbiter_i (
    .clk        (clk),
    .rst        (rst),
    .ram_hit_i  (ram_hit),
    .port_hit_i (port_hit),
    .rd_n_i     (rd_n_i),
    .wr_n_i     (wr_n_i),
    .sel_o      (sel)
  );

  assign addr_o       = addr_held;
  assign ram_sel_n_o  = !sel.ram;
  assign rom_sel_n_o  = !sel.rom;
  assign port_sel_n_o = !sel.port;

endmodule

// File: tb/mux_bus_addr_decoder_tb.sv
module mux_bus_addr_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ad  = '0;
  logic        ale = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [15:0] addr_o;
  logic        ram_n, rom_n, port_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_addr_decoder dut_i (
    .clk          (clk),
    .rst          (rst),
    .ad_i         (ad),
    .ale_i        (ale),
    .rd_n_i       (rd_n),
    .wr_n_i       (wr_n),
    .addr_o       (addr_o),
    .ram_sel_n_o  (ram_n),
    .rom_sel_n_o  (rom_n),
    .port_sel_n_o (port_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected selects for held address a under strobes rd/wr.
  task automatic check_sel(input logic [15:0] a, input logic rd, input logic wr);
    logic e_ram, e_win, e_port, e_rom;
    e_ram  = (a[15:13] == 3'b111);
    e_win  = (a[15:9] == 7'b1101111);
    e_port = e_win && !wr && rd;
    e_rom  = !e_ram && !e_win;
    check(ram_n == !e_ram, "R4 ram select", {31'd0, ram_n}, {31'd0, !e_ram});
    if (e_win && !(!wr && rd))
      check(port_n == 1'b1, "R6 port select", {31'd0, port_n}, 32'd1);
    else
      check(port_n == !e_port, "R5 port select", {31'd0, port_n}, {31'd0, !e_port});
    check(rom_n == !e_rom, "R7 rom select", {31'd0, rom_n}, {31'd0, !e_rom});
    check(({ram_n, rom_n, port_n} == 3'b111) || ($countones(~{ram_n, rom_n, port_n}) == 1),
          "R8 single select", {29'd0, ram_n, rom_n, port_n}, 32'h7);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(addr_o == 16'h0, "R1 reset addr", {16'd0, addr_o}, 32'h0);
    check({ram_n, rom_n, port_n} == 3'b111, "R1 reset selects",
          {29'd0, ram_n, rom_n, port_n}, 32'h7);
    rst = 1'b0;
  endtask

  task automatic t_hold();
    @(negedge clk);
    ale = 1'b1; ad = 16'hE123; rd_n = 1'b0; wr_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(addr_o == 16'hE123, "R2 capture", {16'd0, addr_o}, 32'hE123);
    ale = 1'b0; ad = 16'h0456;
    @(posedge clk); @(negedge clk);
    check(addr_o == 16'hE123, "R3 hold", {16'd0, addr_o}, 32'hE123);
    ad = 16'hDE10; rd_n = 1'b1; wr_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(addr_o == 16'hE123, "R3 hold bus change", {16'd0, addr_o}, 32'hE123);
    check_sel(16'hE123, 1'b1, 1'b0);
    // Port address with ale low must not move the held RAM address.
    ad = 16'hDFFE;
    @(posedge clk); @(negedge clk);
    check(addr_o == 16'hE123, "R3 hold port addr", {16'd0, addr_o}, 32'hE123);
    check(port_n == 1'b1, "R3 no port while held", {31'd0, port_n}, 32'd1);
  endtask

  // Streams addresses with ale high; selects lag the held address by one edge.
  task automatic t_sweep(input logic rd, input logic wr, input int low_step);
    logic [15:0] prev = '0;
    bit have = 1'b0;
    @(negedge clk);
    rd_n = rd; wr_n = wr; ale = 1'b1;
    for (int a = 0; a < 65536; a++) begin
      if (a < 32'hD000 && (a % low_step) != 0) continue;
      ad = a[15:0];
      @(posedge clk); @(negedge clk);
      if (have) check_sel(prev, rd, wr);
      check(addr_o == a[15:0], "R2 follow", {16'd0, addr_o}, a);
      prev = a[15:0];
      have = 1'b1;
    end
    ale = 1'b0;
    @(posedge clk); @(negedge clk);
    check_sel(prev, rd, wr);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_hold();
    t_sweep(1'b1, 1'b0, 1);   // write, every address
    t_sweep(1'b0, 1'b1, 13);  // read
    t_sweep(1'b1, 1'b1, 13);  // idle
    t_sweep(1'b0, 1'b0, 13);  // clash
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule